// File: doc/BRIEF.md
# Single-Window Acknowledgement and Poll Retry Controller

This block supervises the acknowledgement of information frames on a link that allows only one unacknowledged frame at a time. A transmit request from the CPU is accepted only while the link is idle. The block then asks a frame generator for one I frame, which carries the current send sequence number. When the generator reports that the frame has left, a prescaled timer starts. Any further transmit request is refused until an acknowledgement arrives.

An acknowledgement is a received S or I frame whose receive sequence number is one more than the current send number. A matching acknowledgement advances the send number, stops the timer, raises an acknowledge pulse and returns the block to idle. If the timer runs out first, the block asks the generator for an S frame with the poll bit set. The poll is RR or RNR according to the local receiver-busy input, and the timer restarts. Polling repeats until the programmed retry count is used up. The next timeout then raises a failure pulse and parks the block in a failed state that only a CPU link reset clears.

Top module: `ack_poll_supervisor`

## Requirements
- R1: After a synchronous active-low reset, `o_busy`, `o_failed` and all four pulse outputs are 0, and `o_tx_ns` is 0.
- R2: A `i_tx_req` seen in the idle state makes `o_iframe_req` high for exactly one cycle in the next cycle. In that cycle `o_busy` is 1 and `o_tx_ns` holds the send number the frame carries.
- R3: `i_tx_req` has no effect while `o_busy` is 1: no `o_iframe_req` is produced.
- R4: In the waiting state (after `i_sent`), a received frame with `i_rx_kind` 2'b00 (I) or 2'b01 (S) and `i_rx_nr` equal to `o_tx_ns`+1 modulo 2^SEQ_W produces a one-cycle `o_ack_irq` in the next cycle. In that same cycle `o_tx_ns` has advanced by one (wrapping) and `o_busy` is 0.
- R5: A received frame is ignored in each of these cases: its N(R) does not match, its `i_rx_kind` is 2'b10 or 2'b11 (U or reserved), or it arrives outside the waiting state (before `i_sent`, or after failure).
- R6: With timer load value T and prescale P, a timeout pulse (`o_poll_req` or `o_fail_irq`) appears (T+1)·P cycles after the edge that sampled `i_sent`. The timer restarts on each poll, so each later timeout comes another (T+1)·P cycles after the previous one.
- R7: On a poll, `o_poll_rnr` equals the value `i_rx_busy` had at the expiring edge (1 = RNR, 0 = RR).
- R8: With retry limit N2, the first N2 timeouts each produce `o_poll_req`. The timeout after those produces `o_fail_irq`, and `o_failed` becomes 1.
- R9: `o_failed` stays 1 until `i_link_reset`. A link reset in any state returns the block to idle with `o_tx_ns` = 0 in the next cycle.
- R10: At most one of `o_iframe_req`, `o_poll_req`, `o_ack_irq`, `o_fail_irq` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timeout | input | TMR_W | Timer load value T (timeout = (T+1)·PRESCALE cycles) |
| cfg_retries | input | RETRY_W | Number of polls N2 before failure |
| i_tx_req | input | 1 | CPU request to send an I frame |
| i_sent | input | 1 | Frame generator: the requested I frame has been sent |
| i_rx_valid | input | 1 | A received frame is presented this cycle |
| i_rx_kind | input | 2 | Received frame type: 00 I, 01 S, 10 U, 11 reserved |
| i_rx_nr | input | SEQ_W | Receive sequence number of the received frame |
| i_rx_busy | input | 1 | Local receiver busy; selects RNR for polls |
| i_link_reset | input | 1 | CPU link reset, leaves the failed state |
| o_iframe_req | output | 1 | Pulse: frame generator should send an I frame |
| o_tx_ns | output | SEQ_W | Current send sequence number |
| o_poll_req | output | 1 | Pulse: send an S frame with poll bit set |
| o_poll_rnr | output | 1 | Poll kind: 1 RNR, 0 RR |
| o_ack_irq | output | 1 | Pulse: outstanding frame acknowledged |
| o_fail_irq | output | 1 | Pulse: retries exhausted |
| o_busy | output | 1 | An I frame is outstanding or the link has failed |
| o_failed | output | 1 | Failed state, held until link reset |

## Verification
The bench measures the exact distance from the sent edge to every timeout, so a timer that is off by one tick or fails to reload on a poll shows up as a wrong cycle count. During each waiting window it injects near-miss frames: U frames carrying the right N(R), and I or S frames whose N(R) is wrong by every possible offset. A matcher that ignores the frame type, or compares against the send number itself rather than send+1, would acknowledge too early. Retry limits of zero through three check that the block fails after the correct number of polls rather than one too few or one too many. Long runs carry the send number through its wrap from 7 to 0. Correct acknowledgements are also offered before `i_sent` and after failure, and a design that accepts them would leave the waiting or failed state when it should not.

// File: rtl/ack_poll_pkg.sv
// Shared types for the acknowledgement/poll supervisor.
// Assumes: two-bit frame-type code delivered by an external frame parser.
package ack_poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SENDING = 2'd1,
        ST_WAIT    = 2'd2,
        ST_FAILED  = 2'd3
    } link_state_e;

    localparam logic [1:0] KIND_I   = 2'b00;
    localparam logic [1:0] KIND_S   = 2'b01;
    localparam logic [1:0] KIND_U   = 2'b10;
    localparam logic [1:0] KIND_RSV = 2'b11;
endpackage

// File: rtl/ack_poll_timer.sv
// Prescaled down-counting response timer.
// Does: on i_load, clears the prescaler and loads i_period. While i_run is set,
// it decrements once every PRESCALE cycles. o_expire is a combinational
// one-cycle flag raised on the tick that finds the count already at zero.
// Assumes: the owner reloads or stops the timer in the cycle of o_expire.
module ack_poll_timer #(
    parameter int PRESCALE = 4,
    parameter int TMR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_load,
    input  logic             i_run,
    input  logic [TMR_W-1:0] i_period,
    output logic             o_expire
);
    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    logic [PS_W-1:0]  presc_q;
    logic [TMR_W-1:0] count_q;
    logic             tick;

    // Prescaler wraps at PRESCALE-1; this is the tick instant.
    assign tick     = (presc_q == PS_LAST);
    assign o_expire = i_run && tick && (count_q == '0);

    // Advance prescaler and count, with load taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            count_q <= '0;
        end else if (i_load) begin
            presc_q <= '0;
            count_q <= i_period;
        end else if (i_run) begin
            if (tick) begin
                presc_q <= '0;
                if (count_q != '0) count_q <= count_q - 1'b1;
            end else begin
                presc_q <= presc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ack_poll_match.sv
// Acknowledgement matcher.
// Does: flags a received I or S frame whose N(R) equals the send number plus
// one, modulo 2^SEQ_W. U and reserved frame kinds never match.
// Assumes: i_valid is a single-cycle strobe from the frame parser.
module ack_poll_match
    import ack_poll_pkg::*;
#(
    parameter int SEQ_W = 3
) (
    input  logic             i_valid,
    input  logic [1:0]       i_kind,
    input  logic [SEQ_W-1:0] i_nr,
    input  logic [SEQ_W-1:0] i_ns,
    output logic             o_hit
);
    logic [SEQ_W-1:0] want_nr;
    logic             kind_ok;

    // Expected N(R) and admissible frame kinds.
    always_comb begin
        want_nr = i_ns + 1'b1;
        kind_ok = (i_kind == KIND_I) || (i_kind == KIND_S);
        o_hit   = i_valid && kind_ok && (i_nr == want_nr);
    end
endmodule

// File: rtl/ack_poll_retry.sv
// Poll attempt counter.
// Does: counts polls issued for the outstanding frame and reports when the
// programmed limit has been reached. Saturates at its maximum value.
// Assumes: i_clear and i_step are never both set in one cycle.
module ack_poll_retry #(
    parameter int RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               i_clear,
    input  logic               i_step,
    input  logic [RETRY_W-1:0] i_limit,
    output logic               o_exhausted
);
    logic [RETRY_W-1:0] polls_q;

    assign o_exhausted = (polls_q >= i_limit);

    // Count polls; clear when a new frame starts or the link resets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            polls_q <= '0;
        end else if (i_clear) begin
            polls_q <= '0;
        end else if (i_step && (polls_q != '1)) begin
            polls_q <= polls_q + 1'b1;
        end
    end
endmodule

// File: rtl/ack_poll_supervisor.sv
// Single-window acknowledgement and poll retry supervisor (top).
// Does: admits one I frame at a time, times its acknowledgement, polls with
// RR/RNR on timeout up to cfg_retries times, then fails until link reset.
// Assumes: i_sent arrives once per o_iframe_req. cfg_* are stable while a
// frame is outstanding. Receive strobes are single-cycle.
module ack_poll_supervisor
    import ack_poll_pkg::*;
#(
    parameter int SEQ_W    = 3,
    parameter int TMR_W    = 8,
    parameter int RETRY_W  = 3,
    parameter int PRESCALE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TMR_W-1:0]   cfg_timeout,
    input  logic [RETRY_W-1:0] cfg_retries,
    input  logic               i_tx_req,
    input  logic               i_sent,
    input  logic               i_rx_valid,
    input  logic [1:0]         i_rx_kind,
    input  logic [SEQ_W-1:0]   i_rx_nr,
    input  logic               i_rx_busy,
    input  logic               i_link_reset,
    output logic               o_iframe_req,
    output logic [SEQ_W-1:0]   o_tx_ns,
    output logic               o_poll_req,
    output logic               o_poll_rnr,
    output logic               o_ack_irq,
    output logic               o_fail_irq,
    output logic               o_busy,
    output logic               o_failed
);
    link_state_e      state_q, state_d;
    logic [SEQ_W-1:0] ns_q, ns_d;
    logic             iframe_d, poll_d, rnr_d, ack_d, fail_d;
    logic             tmr_load, tmr_run, tmr_expire;
    logic             retry_clr, retry_step, retry_done;
    logic             nr_match, ack_hit;

    ack_poll_timer #(.PRESCALE(PRESCALE), .TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_load   (tmr_load),
        .i_run    (tmr_run),
        .i_period (cfg_timeout),
        .o_expire (tmr_expire)
    );

    ack_poll_match #(.SEQ_W(SEQ_W)) u_match (
        .i_valid (i_rx_valid),
        .i_kind  (i_rx_kind),
        .i_nr    (i_rx_nr),
        .i_ns    (ns_q),
        .o_hit   (nr_match)
    );

    ack_poll_retry #(.RETRY_W(RETRY_W)) u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .i_clear     (retry_clr),
        .i_step      (retry_step),
        .i_limit     (cfg_retries),
        .o_exhausted (retry_done)
    );

    // Timer runs only while an acknowledgement is awaited.
    assign tmr_run = (state_q == ST_WAIT);
    assign ack_hit = tmr_run && nr_match;

    // Next-state and event decisions; link reset overrides everything.
    always_comb begin
        state_d    = state_q;
        ns_d       = ns_q;
        iframe_d   = 1'b0;
        poll_d     = 1'b0;
        ack_d      = 1'b0;
        fail_d     = 1'b0;
        rnr_d      = o_poll_rnr;
        tmr_load   = 1'b0;
        retry_clr  = 1'b0;
        retry_step = 1'b0;
        if (i_link_reset) begin
            state_d   = ST_IDLE;
            ns_d      = '0;
            retry_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (i_tx_req) begin
                        state_d  = ST_SENDING;
                        iframe_d = 1'b1;
                    end
                end
                ST_SENDING: begin
                    if (i_sent) begin
                        state_d   = ST_WAIT;
                        tmr_load  = 1'b1;
                        retry_clr = 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (ack_hit) begin
                        state_d = ST_IDLE;
                        ns_d    = ns_q + 1'b1;
                        ack_d   = 1'b1;
                    end else if (tmr_expire) begin
                        if (retry_done) begin
                            state_d = ST_FAILED;
                            fail_d  = 1'b1;
                        end else begin
                            poll_d     = 1'b1;
                            rnr_d      = i_rx_busy;
                            retry_step = 1'b1;
                            tmr_load   = 1'b1;
                        end
                    end
                end
                ST_FAILED: begin
                    state_d = ST_FAILED;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Register state, send number and the event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            ns_q         <= '0;
            o_iframe_req <= 1'b0;
            o_poll_req   <= 1'b0;
            o_poll_rnr   <= 1'b0;
            o_ack_irq    <= 1'b0;
            o_fail_irq   <= 1'b0;
        end else begin
            state_q      <= state_d;
            ns_q         <= ns_d;
            o_iframe_req <= iframe_d;
            o_poll_req   <= poll_d;
            o_poll_rnr   <= rnr_d;
            o_ack_irq    <= ack_d;
            o_fail_irq   <= fail_d;
        end
    end

    assign o_tx_ns  = ns_q;
    assign o_busy   = (state_q != ST_IDLE);
    assign o_failed = (state_q == ST_FAILED);
endmodule

// File: rtl/ack_poll_checker.sv
// Port-level property checker for ack_poll_supervisor, attached by bind.
// Assumes: synchronous active-low reset; all properties disabled during reset.
module ack_poll_checker #(
    parameter int SEQ_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             i_tx_req,
    input logic             i_rx_busy,
    input logic             i_link_reset,
    input logic             o_iframe_req,
    input logic [SEQ_W-1:0] o_tx_ns,
    input logic             o_poll_req,
    input logic             o_poll_rnr,
    input logic             o_ack_irq,
    input logic             o_fail_irq,
    input logic             o_busy,
    input logic             o_failed
);
    AST_IFRAME_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        o_iframe_req |-> o_busy && !o_failed); // R2
    AST_REFUSE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        o_busy && !i_link_reset && i_tx_req |=> !o_iframe_req); // R3
    AST_ACK_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        o_ack_irq |-> !o_busy && !o_failed); // R4
    AST_ACK_ADVANCES_NS: assert property (@(posedge clk) disable iff (!rst_n)
        o_ack_irq |-> o_tx_ns == SEQ_W'($past(o_tx_ns) + 1'b1)); // R4
    AST_POLL_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        o_poll_req |-> o_busy && !o_failed); // R6
    AST_POLL_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        o_poll_req |-> o_poll_rnr == $past(i_rx_busy)); // R7
    AST_FAIL_ENTERS_FAILED: assert property (@(posedge clk) disable iff (!rst_n)
        o_fail_irq |-> o_failed); // R8
    AST_FAILED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        o_failed && !i_link_reset |=> o_failed); // R9
    AST_LINK_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        i_link_reset |=> !o_busy && o_tx_ns == '0); // R9
    AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_iframe_req, o_poll_req, o_ack_irq, o_fail_irq})); // R10
endmodule

bind ack_poll_supervisor ack_poll_checker #(.SEQ_W(SEQ_W)) i_ack_poll_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .i_tx_req     (i_tx_req),
    .i_rx_busy    (i_rx_busy),
    .i_link_reset (i_link_reset),
    .o_iframe_req (o_iframe_req),
    .o_tx_ns      (o_tx_ns),
    .o_poll_req   (o_poll_req),
    .o_poll_rnr   (o_poll_rnr),
    .o_ack_irq    (o_ack_irq),
    .o_fail_irq   (o_fail_irq),
    .o_busy       (o_busy),
    .o_failed     (o_failed)
);

// File: tb/test_ack_poll_supervisor.sv
module test_ack_poll_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ_W      = 3;
    localparam int TMR_W      = 8;
    localparam int RETRY_W    = 3;
    localparam int PRESCALE   = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [TMR_W-1:0]   cfg_timeout = '0;
    logic [RETRY_W-1:0] cfg_retries = '0;
    logic               tx_req = 1'b0, sent = 1'b0, rx_valid = 1'b0;
    logic [1:0]         rx_kind = 2'b00;
    logic [SEQ_W-1:0]   rx_nr = '0;
    logic               rx_busy = 1'b0, link_reset = 1'b0;
    logic               o_iframe_req, o_poll_req, o_poll_rnr, o_ack_irq, o_fail_irq, o_busy, o_failed;
    logic [SEQ_W-1:0]   o_tx_ns;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [SEQ_W-1:0] exp_ns = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ack_poll_supervisor #(.SEQ_W(SEQ_W), .TMR_W(TMR_W), .RETRY_W(RETRY_W), .PRESCALE(PRESCALE))
    i_ack_poll_supervisor (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout), .cfg_retries(cfg_retries),
        .i_tx_req(tx_req), .i_sent(sent), .i_rx_valid(rx_valid), .i_rx_kind(rx_kind),
        .i_rx_nr(rx_nr), .i_rx_busy(rx_busy), .i_link_reset(link_reset),
        .o_iframe_req(o_iframe_req), .o_tx_ns(o_tx_ns), .o_poll_req(o_poll_req),
        .o_poll_rnr(o_poll_rnr), .o_ack_irq(o_ack_irq), .o_fail_irq(o_fail_irq),
        .o_busy(o_busy), .o_failed(o_failed)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int timeout_cycles(input int t);
        return (t + 1) * PRESCALE;
    endfunction

    function automatic logic [SEQ_W-1:0] ack_nr(input logic [SEQ_W-1:0] ns);
        return SEQ_W'(ns + 1);
    endfunction

    function automatic int pulse_count();
        return int'(o_iframe_req) + int'(o_poll_req) + int'(o_ack_irq) + int'(o_fail_irq);
    endfunction

    task automatic clear_inputs();
        tx_req = 1'b0; sent = 1'b0; rx_valid = 1'b0; link_reset = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R2: accept a transmit request in idle
    task automatic send_iframe();
        tx_req = 1'b1;
        step();
        tx_req = 1'b0;
        check(o_iframe_req && o_busy && o_tx_ns == exp_ns, "R2 iframe request", int'(o_tx_ns), int'(exp_ns));
        step();
        check(!o_iframe_req, "R2 single-cycle request", int'(o_iframe_req), 0);
    endtask

    task automatic frame_sent();
        sent = 1'b1;
        step();
        sent = 1'b0;
    endtask

    // R4: present a correct acknowledgement
    task automatic give_ack();
        rx_valid = 1'b1;
        rx_kind  = ($urandom % 2) ? 2'b01 : 2'b00;
        rx_nr    = ack_nr(exp_ns);
        step();
        rx_valid = 1'b0;
        check(o_ack_irq && !o_busy && o_tx_ns == ack_nr(exp_ns), "R4 acknowledgement", int'(o_tx_ns), int'(ack_nr(exp_ns)));
        exp_ns = ack_nr(exp_ns);
        step();
        check(!o_ack_irq && !o_busy, "R4 ack pulse ends", int'(o_ack_irq), 0);
    endtask

    // R5/R3/R6/R7/R8/R10: wait for one timeout, optionally with near-miss noise
    task automatic expect_expiry(input bit want_fail, input bit noise, input int tmo);
        int  cnt = 0;
        bit  seen = 1'b0;
        bit  stray_ack = 1'b0, stray_req = 1'b0, multi = 1'b0;
        bit  bsy = 1'($urandom % 2);
        rx_busy = bsy;
        while (!seen && cnt < 400) begin
            if (noise && cnt == 0) begin
                tx_req   = 1'b1;
                rx_valid = 1'b1;
                if ($urandom % 2) begin
                    rx_kind = ($urandom % 2) ? 2'b10 : 2'b11;
                    rx_nr   = ack_nr(exp_ns);
                end else begin
                    rx_kind = ($urandom % 2) ? 2'b01 : 2'b00;
                    rx_nr   = SEQ_W'(exp_ns + 2 + ($urandom % 7));
                end
            end else begin
                tx_req = 1'b0; rx_valid = 1'b0;
            end
            step();
            cnt++;
            if (o_ack_irq) stray_ack = 1'b1;
            if (o_iframe_req) stray_req = 1'b1;
            if (pulse_count() > 1) multi = 1'b1;
            if (o_poll_req || o_fail_irq) seen = 1'b1;
        end
        tx_req = 1'b0; rx_valid = 1'b0;
        check(cnt == timeout_cycles(tmo), "R6 timeout distance", cnt, timeout_cycles(tmo));
        check(!stray_ack, "R5 near-miss frame ignored", int'(stray_ack), 0);
        if (noise) check(!stray_req, "R3 request refused while busy", int'(stray_req), 0);
        check(!multi, "R10 one event per cycle", int'(multi), 0);
        if (want_fail) begin
            check(o_fail_irq && o_failed && !o_poll_req, "R8 failure after retries", int'(o_fail_irq), 1);
        end else begin
            check(o_poll_req && !o_fail_irq && !o_failed, "R8 poll before limit", int'(o_poll_req), 1);
            check(o_poll_rnr == bsy, "R7 poll kind", int'(o_poll_rnr), int'(bsy));
        end
    endtask

    task automatic do_link_reset();
        link_reset = 1'b1;
        step();
        link_reset = 1'b0;
        exp_ns = '0;
        check(!o_busy && !o_failed && o_tx_ns == '0, "R9 link reset to idle", int'(o_busy), 0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!o_busy && !o_failed && pulse_count() == 0 && o_tx_ns == '0, "R1 reset state", int'(o_busy), 0);

        // Directed: zero retries, fail at first timeout, then failed-state behaviour
        cfg_timeout = 8'd0; cfg_retries = 3'd0;
        send_iframe();
        // R5: correct ack before the frame is sent is ignored
        rx_valid = 1'b1; rx_kind = 2'b01; rx_nr = ack_nr(exp_ns);
        step();
        rx_valid = 1'b0;
        check(!o_ack_irq && o_busy && o_tx_ns == exp_ns, "R5 ack before sent ignored", int'(o_ack_irq), 0);
        frame_sent();
        expect_expiry(1'b1, 1'b0, 0);
        rx_valid = 1'b1; rx_kind = 2'b00; rx_nr = ack_nr(exp_ns); tx_req = 1'b1;
        step();
        clear_inputs();
        repeat (20) step();
        check(o_failed && o_busy && !o_ack_irq && !o_iframe_req, "R9 failed state holds", int'(o_failed), 1);
        do_link_reset();

        // Directed: plain acknowledged transfers across the send-number wrap
        cfg_timeout = 8'd3; cfg_retries = 3'd2;
        for (int k = 0; k < 10; k++) begin
            send_iframe();
            frame_sent();
            give_ack();
        end
        check(o_tx_ns == 3'd2, "R4 send number wraps", int'(o_tx_ns), 2);

        // Directed: full retry ladder to failure with limit 3
        cfg_timeout = 8'd1; cfg_retries = 3'd3;
        send_iframe();
        frame_sent();
        for (int k = 0; k < 3; k++) expect_expiry(1'b0, 1'b1, 1);
        expect_expiry(1'b1, 1'b1, 1);
        do_link_reset();

        // Constrained random transactions
        for (int it = 0; it < 60; it++) begin
            int t  = $urandom % 4;
            int n2 = $urandom % 4;
            int p  = $urandom % (n2 + 2);
            cfg_timeout = TMR_W'(t);
            cfg_retries = RETRY_W'(n2);
            send_iframe();
            frame_sent();
            if (p == n2 + 1) begin
                for (int k = 0; k < n2; k++) expect_expiry(1'b0, 1'($urandom % 2), t);
                expect_expiry(1'b1, 1'($urandom % 2), t);
                do_link_reset();
            end else begin
                for (int k = 0; k < p; k++) expect_expiry(1'b0, 1'($urandom % 2), t);
                give_ack();
            end
        end

        done = 1'b1;
        report();
        $finish;
    end
endmodule